// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management side of an Ethernet PHY as seen by a host. The host reaches it through a small 32-bit register bus with one write strobe and no read strobe. A write to the command word register is decoded as one management transaction. The transaction names a PHY register, says whether it reads or writes, and carries 16 bits of data. A write transaction updates the modelled PHY registers. A read transaction replaces the stored command word with the register's value. Every transaction, read or write, completes in the cycle it is issued and raises a sticky completion flag.

The model also watches a link-state input. Each edge of that input updates the link and auto-negotiation status bits and posts interrupt-source events. Auto-negotiation is treated as finishing instantly. Some registers apply fixed write masks or force bits on. The interrupt-source register is cleared by a management read. Serial management timing and the electrical interface are not modelled.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset the command word and the completion flag read 0. The PHY registers read as follows: control 0x3000; advertisement 0x01E1; interrupt mask 0; status 0x7809, with bits 5 and 2 also set (0x782D) when `link_up` is high. The interrupt source is 0x00C0 when `link_up` is high and 0x0010 when it is low.
- R2: Bus offset 0 holds the command word. Its fields are: bit 28 = 1 for write and 0 for read; bits 26:18 = PHY register address; bits 15:0 = data. A write transaction leaves the written word in offset 0. A read transaction replaces it with zero-extended 16-bit register data, visible one cycle later.
- R3: Every transaction sets the completion flag (bus offset 1, bit 0). The flag holds until the host writes offset 1 with bit 0 = 1. Writing bit 0 = 0 leaves it set.
- R4: Writing register 0 with bit 15 clear stores the data ANDed with 0x7980. If data bit 12 is 1, status bit 5 is also set in the same cycle.
- R5: Writing register 4 stores the data ANDed with 0x2D7F, then ORed with 0x0080.
- R6: Writing register 30 stores data bits 7:0 as the interrupt mask. The mask reads back zero-extended.
- R7: Registers 2, 3, 5 and 6 read 0x0007, 0xC0D1, 0x0F71 and 0x0001, and ignore writes.
- R8: Reading register 29 returns the interrupt source and clears it. A following read returns 0 unless a link edge occurred in between.
- R9: On a rising edge of `link_up`, status bits 5 and 2 are set and interrupt-source bits 7 and 6 are set. On a falling edge, status bits 5 and 2 are cleared and interrupt-source bit 4 is set. Each edge takes effect one cycle after it is sampled.
- R10: Writing register 0 with bit 15 set restores control, status, advertisement, mask and interrupt source to the R1 values for the current `link_up`.
- R11: Addresses above 31, registers 17, 18, 27 and 31, and every other unlisted address read 0 and ignore writes. A register is never aliased by address bits above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link state, sampled every cycle |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | BUS_AW | Register bus word offset (0 command word, 1 completion flag) |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data for `bus_addr`, combinational |

## Verification
The assertions assume that `link_up` is synchronous to `clk`. They also assume a bus write targets only one offset per cycle, so a transaction and a flag clear never collide in one write. The interrupt-clear property is guarded against link edges, because an edge in the same cycle legitimately posts new events. The bench changes `link_up` only at falling clock edges and lets the edge settle before issuing the next transaction. It never clears the completion flag in the same cycle as a transaction.

// File: rtl/phy_mgmt_pkg.sv
// Package: shared widths, command-word field positions, PHY register
// addresses and reset constants for the PHY management register model.
// Assumes a single modelled PHY with 16-bit registers.
package phy_mgmt_pkg;
    localparam int WORD_W   = 32;
    localparam int REG_W    = 16;
    localparam int RADDR_W  = 9;
    localparam int WR_BIT   = 28;
    localparam int RADDR_LO = 18;
    localparam int RADDR_HI = RADDR_LO + RADDR_W - 1;

    localparam logic [RADDR_W-1:0] RA_CTRL  = 9'd0;
    localparam logic [RADDR_W-1:0] RA_STAT  = 9'd1;
    localparam logic [RADDR_W-1:0] RA_ID_HI = 9'd2;
    localparam logic [RADDR_W-1:0] RA_ID_LO = 9'd3;
    localparam logic [RADDR_W-1:0] RA_ADV   = 9'd4;
    localparam logic [RADDR_W-1:0] RA_PEER  = 9'd5;
    localparam logic [RADDR_W-1:0] RA_EXPN  = 9'd6;
    localparam logic [RADDR_W-1:0] RA_ISRC  = 9'd29;
    localparam logic [RADDR_W-1:0] RA_IMSK  = 9'd30;

    localparam logic [REG_W-1:0] CTRL_RST  = 16'h3000;
    localparam logic [REG_W-1:0] STAT_RST  = 16'h7809;
    localparam logic [REG_W-1:0] ADV_RST   = 16'h01E1;
    localparam logic [REG_W-1:0] CTRL_MASK = 16'h7980;
    localparam logic [REG_W-1:0] ADV_MASK  = 16'h2D7F;
    localparam logic [REG_W-1:0] ADV_FORCE = 16'h0080;
    localparam logic [REG_W-1:0] STAT_LINK = 16'h0024;
    localparam logic [REG_W-1:0] STAT_ANEG = 16'h0020;

    localparam logic [7:0] EV_UP   = 8'hC0;
    localparam logic [7:0] EV_DOWN = 8'h10;

    // Status after a link evaluation.
    function automatic logic [REG_W-1:0] link_stat(input logic [REG_W-1:0] s, input logic up);
        return up ? (s | STAT_LINK) : (s & ~STAT_LINK);
    endfunction

    // Interrupt source after a link evaluation.
    function automatic logic [7:0] link_isrc(input logic [7:0] i, input logic up);
        return up ? (i | EV_UP) : (i | EV_DOWN);
    endfunction
endpackage

// File: rtl/phy_cmd_decode.sv
// Module: phy_cmd_decode
// Splits a host bus write into a management transaction (offset 0) or a
// completion-flag clear request (offset 1). Purely combinational.
// Assumes one bus write per cycle.
module phy_cmd_decode
    import phy_mgmt_pkg::*;
#(
    parameter int BUS_AW = 2
) (
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               wr_flag,
    input  logic [RADDR_W-1:0] wr_raddr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               clr_bit,
    output logic               cmd_valid,
    output logic               cmd_wr,
    output logic [RADDR_W-1:0] cmd_addr,
    output logic [REG_W-1:0]   cmd_data,
    output logic               flag_clr
);
    localparam logic [BUS_AW-1:0] OFS_CMD  = BUS_AW'(0);
    localparam logic [BUS_AW-1:0] OFS_FLAG = BUS_AW'(1);

    // Classify the bus write and pass the command fields through.
    always_comb begin
        cmd_valid = bus_wr && (bus_addr == OFS_CMD);
        cmd_wr    = wr_flag;
        cmd_addr  = wr_raddr;
        cmd_data  = wr_data;
        flag_clr  = bus_wr && (bus_addr == OFS_FLAG) && clr_bit;
    end
endmodule

// File: rtl/phy_regfile.sv
// Module: phy_regfile
// Holds the modelled PHY registers, applies write masks, clear-on-read
// and link-edge events, and provides combinational read data for the
// addressed register. Assumes link_up is synchronous to clk.
module phy_regfile
    import phy_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    input  logic               cmd_valid,
    input  logic               cmd_wr,
    input  logic [RADDR_W-1:0] cmd_addr,
    input  logic [REG_W-1:0]   cmd_data,
    output logic [REG_W-1:0]   rd_val
);
    logic [REG_W-1:0] ctrl_q, ctrl_n;
    logic [REG_W-1:0] stat_q, stat_n;
    logic [REG_W-1:0] adv_q,  adv_n;
    logic [7:0]       imsk_q, imsk_n;
    logic [7:0]       isrc_q, isrc_n;
    logic             link_q;
    logic             do_wr, do_rd, soft_rst, link_edge;

    // Qualify transactions and detect link edges.
    always_comb begin
        do_wr     = cmd_valid && cmd_wr;
        do_rd     = cmd_valid && !cmd_wr;
        soft_rst  = do_wr && (cmd_addr == RA_CTRL) && cmd_data[15];
        link_edge = (link_up != link_q);
    end

    // Next-state: transaction effects first, then link evaluation.
    always_comb begin
        ctrl_n = ctrl_q;
        stat_n = stat_q;
        adv_n  = adv_q;
        imsk_n = imsk_q;
        isrc_n = isrc_q;
        if (soft_rst) begin
            ctrl_n = CTRL_RST;
            stat_n = STAT_RST;
            adv_n  = ADV_RST;
            imsk_n = '0;
            isrc_n = '0;
        end else if (do_wr) begin
            case (cmd_addr)
                RA_CTRL: begin
                    ctrl_n = cmd_data & CTRL_MASK;
                    if (cmd_data[12]) stat_n = stat_q | STAT_ANEG;
                end
                RA_ADV:  adv_n  = (cmd_data & ADV_MASK) | ADV_FORCE;
                RA_IMSK: imsk_n = cmd_data[7:0];
                default: ;
            endcase
        end else if (do_rd && cmd_addr == RA_ISRC) begin
            isrc_n = '0;
        end
        if (soft_rst || link_edge) begin
            stat_n = link_stat(stat_n, link_up);
            isrc_n = link_isrc(isrc_n, link_up);
        end
    end

    // Register update with link-aware reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            stat_q <= link_stat(STAT_RST, link_up);
            adv_q  <= ADV_RST;
            imsk_q <= '0;
            isrc_q <= link_isrc(8'h00, link_up);
            link_q <= link_up;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            adv_q  <= adv_n;
            imsk_q <= imsk_n;
            isrc_q <= isrc_n;
            link_q <= link_up;
        end
    end

    // Read multiplexer; unlisted addresses return zero.
    always_comb begin
        case (cmd_addr)
            RA_CTRL:  rd_val = ctrl_q;
            RA_STAT:  rd_val = stat_q;
            RA_ID_HI: rd_val = 16'h0007;
            RA_ID_LO: rd_val = 16'hC0D1;
            RA_ADV:   rd_val = adv_q;
            RA_PEER:  rd_val = 16'h0F71;
            RA_EXPN:  rd_val = 16'h0001;
            RA_ISRC:  rd_val = {8'h00, isrc_q};
            RA_IMSK:  rd_val = {8'h00, imsk_q};
            default:  rd_val = '0;
        endcase
    end

    a_r4_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0);
    a_r5_adv_forced: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q[7] && ((adv_q & ~(ADV_MASK | ADV_FORCE)) == '0));
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && cmd_addr == RA_ISRC && !link_edge) |=> (isrc_q == '0));
    a_r9_link_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !link_q) |=> ((stat_q & STAT_LINK) == STAT_LINK) && isrc_q[7] && isrc_q[6]);
    a_r9_link_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && link_q) |=> ((stat_q & STAT_LINK) == '0) && isrc_q[4]);
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_q == CTRL_RST) && (adv_q == ADV_RST) && (imsk_q == '0));
endmodule

// File: rtl/phy_mgmt_model.sv
// Module: phy_mgmt_model (top)
// Host-facing register bus for the PHY management model. Offset 0 is the
// command word, offset 1 bit 0 the sticky completion flag (write 1 clears).
// Assumes single-cycle bus writes and combinational reads without side effects.
module phy_mgmt_model
    import phy_mgmt_pkg::*;
#(
    parameter int BUS_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    logic               cmd_valid, cmd_wr, flag_clr;
    logic [RADDR_W-1:0] cmd_addr;
    logic [REG_W-1:0]   cmd_data, rd_val;
    logic [WORD_W-1:0]  frame_q;
    logic               done_q;

    phy_cmd_decode #(.BUS_AW(BUS_AW)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_flag   (bus_wdata[WR_BIT]),
        .wr_raddr  (bus_wdata[RADDR_HI:RADDR_LO]),
        .wr_data   (bus_wdata[REG_W-1:0]),
        .clr_bit   (bus_wdata[0]),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .flag_clr  (flag_clr)
    );

    phy_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rd_val    (rd_val)
    );

    // Command word: keep written word, or replace with read result.
    always_ff @(posedge clk) begin
        if (!rst_n)         frame_q <= '0;
        else if (cmd_valid) frame_q <= cmd_wr ? bus_wdata : {{(WORD_W-REG_W){1'b0}}, rd_val};
    end

    // Sticky completion flag, set by any transaction, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_q <= 1'b0;
        else if (cmd_valid) done_q <= 1'b1;
        else if (flag_clr)  done_q <= 1'b0;
    end

    // Bus read multiplexer.
    always_comb begin
        case (bus_addr)
            BUS_AW'(0): bus_rdata = frame_q;
            BUS_AW'(1): bus_rdata = {{(WORD_W-1){1'b0}}, done_q};
            default:    bus_rdata = '0;
        endcase
    end

    a_r3_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done_q);
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !flag_clr) |=> done_q);
    a_r2_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_wr) |=> (frame_q == $past(bus_wdata)));
    a_r2_read_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_wr) |=> (frame_q[WORD_W-1:REG_W] == '0));
endmodule

// File: tb/test_phy_mgmt_model.sv
module test_phy_mgmt_model;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    phy_mgmt_model #(.BUS_AW(2)) i_phy_mgmt_model (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic phy_wr(input int ra, input logic [15:0] d);
        bus_write(2'd0, (32'd1 << 28) | (32'(ra) << 18) | {16'h0, d});
    endtask

    task automatic phy_rd(input int ra, output logic [15:0] d);
        logic [31:0] w;
        bus_write(2'd0, 32'(ra) << 18);
        bus_read(2'd0, w);
        check("R2 read upper zero", {16'h0, w[31:16]}, 32'h0);
        d = w[15:0];
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] w; logic [15:0] d;
        bus_read(2'd0, w); check("R1 command word", w, 32'h0);
        bus_read(2'd1, w); check("R1 flag", w, 32'h0);
        phy_rd(0, d);  check("R1 control", {16'h0, d}, 32'h3000);
        phy_rd(1, d);  check("R1 status", {16'h0, d}, 32'h782D);
        phy_rd(4, d);  check("R1 adv", {16'h0, d}, 32'h01E1);
        phy_rd(30, d); check("R1 mask", {16'h0, d}, 32'h0);
        phy_rd(29, d); check("R1 isrc", {16'h0, d}, 32'h00C0);
        phy_rd(29, d); check("R8 isrc cleared", {16'h0, d}, 32'h0);
    endtask

    task automatic t_flag;
        logic [31:0] w;
        bus_read(2'd1, w); check("R3 flag set", w, 32'h1);
        bus_write(2'd1, 32'h0);
        bus_read(2'd1, w); check("R3 write 0 keeps", w, 32'h1);
        bus_write(2'd1, 32'h1);
        bus_read(2'd1, w); check("R3 write 1 clears", w, 32'h0);
        phy_wr(30, 16'h0000);
        bus_read(2'd1, w); check("R3 write sets flag", w, 32'h1);
        bus_read(2'd0, w); check("R2 write word kept", w, 32'h1078_0000);
    endtask

    task automatic t_consts;
        logic [15:0] d;
        phy_rd(2, d); check("R7 reg2", {16'h0, d}, 32'h0007);
        phy_rd(3, d); check("R7 reg3", {16'h0, d}, 32'hC0D1);
        phy_rd(5, d); check("R7 reg5", {16'h0, d}, 32'h0F71);
        phy_rd(6, d); check("R7 reg6", {16'h0, d}, 32'h0001);
        phy_wr(2, 16'hFFFF);
        phy_rd(2, d); check("R7 reg2 write ignored", {16'h0, d}, 32'h0007);
    endtask

    task automatic t_link;
        logic [15:0] d;
        set_link(1'b0);
        phy_rd(1, d);  check("R9 down status", {16'h0, d}, 32'h7809);
        phy_rd(29, d); check("R9 down isrc", {16'h0, d}, 32'h0010);
        set_link(1'b1);
        phy_rd(1, d);  check("R9 up status", {16'h0, d}, 32'h782D);
        phy_rd(29, d); check("R9 up isrc", {16'h0, d}, 32'h00C0);
    endtask

    task automatic t_ctrl;
        logic [15:0] d;
        set_link(1'b0);
        phy_rd(29, d);
        phy_wr(0, 16'h7FFF);
        phy_rd(0, d); check("R4 control mask", {16'h0, d}, 32'h7980);
        phy_rd(1, d); check("R4 aneg bit", {16'h0, d}, 32'h7829);
        phy_wr(0, 16'h0FFF);
        phy_rd(0, d); check("R4 control mask 2", {16'h0, d}, 32'h0980);
        set_link(1'b1);
        phy_rd(29, d);
    endtask

    task automatic t_adv_mask;
        logic [15:0] d;
        phy_wr(4, 16'hFFFF);
        phy_rd(4, d); check("R5 adv all ones", {16'h0, d}, 32'h2DFF);
        phy_wr(4, 16'h0000);
        phy_rd(4, d); check("R5 adv forced bit", {16'h0, d}, 32'h0080);
        phy_wr(30, 16'h1234);
        phy_rd(30, d); check("R6 mask low byte", {16'h0, d}, 32'h0034);
    endtask

    task automatic t_unimpl;
        logic [15:0] d;
        phy_wr(17, 16'hBEEF);
        phy_rd(17, d);  check("R11 reg17", {16'h0, d}, 32'h0);
        phy_rd(18, d);  check("R11 reg18", {16'h0, d}, 32'h0);
        phy_rd(27, d);  check("R11 reg27", {16'h0, d}, 32'h0);
        phy_rd(31, d);  check("R11 reg31", {16'h0, d}, 32'h0);
        phy_rd(33, d);  check("R11 addr33 no alias", {16'h0, d}, 32'h0);
        phy_rd(511, d); check("R11 addr511", {16'h0, d}, 32'h0);
        phy_wr(62, 16'h00AA);
        phy_rd(30, d);  check("R11 high write ignored", {16'h0, d}, 32'h0034);
    endtask

    task automatic t_soft_reset;
        logic [15:0] d;
        phy_wr(0, 16'h8000);
        phy_rd(0, d);  check("R10 control", {16'h0, d}, 32'h3000);
        phy_rd(4, d);  check("R10 adv", {16'h0, d}, 32'h01E1);
        phy_rd(30, d); check("R10 mask", {16'h0, d}, 32'h0);
        phy_rd(1, d);  check("R10 status", {16'h0, d}, 32'h782D);
        phy_rd(29, d); check("R10 isrc", {16'h0, d}, 32'h00C0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_flag;
        t_consts;
        t_link;
        t_ctrl;
        t_adv_mask;
        t_unimpl;
        t_soft_reset;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule